// File: doc/BRIEF.md
# Cartridge Bank Mapper with Work-RAM Gating

This block is the bank-switching and decode logic of a game cartridge that sits between an 8-bit CPU bus and a separate picture-processor bus. It turns the upper CPU address bits into upper program-ROM address lines. It turns the picture-processor address into the upper address line of an 8 KB character RAM and into a nametable address line. It also produces the enable of an 8 KB work RAM mapped at CPU $6000-$7FFF.

Software loads four 5-bit registers through a serial port. Each CPU write to $8000-$FFFF carries one data bit. The fifth write commits the collected bits to the register chosen by CPU address bits 14:13. In this variant, the top bit of each character-bank register is not an address line. It gates the work RAM instead. In 4 KB character mode, the gate therefore follows whichever character register the picture-processor address selects at that moment.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, the control register holds 5'b01100 and the other three registers hold zero. With these values, $8000 maps bank 0, $C000 maps the last bank, the work RAM is enabled, `ciram_a10` is 0, and `chr_a12` equals picture address bit 12.
- R2: A write to $8000-$FFFF with data bit 7 clear shifts data bit 0 into the loader, least significant bit first. On the fifth such write, the five bits go to the register selected by address bits 14:13 (0 control, 1 character bank 0, 2 character bank 1, 3 program bank) and the loader empties.
- R3: A write to $8000-$FFFF with data bit 7 set empties the loader and sets control bits 3:2 to 2'b11. Control bits 4 and 1:0 are kept.
- R4: With control bits 3:2 = 3, window $8000 maps program-bank bits [PBW-1:0] and window $C000 maps the last bank.
- R5: With control bits 3:2 = 2, window $8000 maps bank 0 and window $C000 maps program-bank bits [PBW-1:0].
- R6: With control bits 3:2 = 0 or 1, both windows switch together. The bank is the program-bank value with its bit 0 replaced by CPU address bit 14.
- R7: With control bit 4 = 0 (8 KB character mode), `chr_a12` equals picture address bit 12, and bit 0 of both character registers has no effect.
- R8: With control bit 4 = 1 (4 KB character mode), `chr_a12` is bit 0 of character register 0 when picture address bit 12 is 0, and bit 0 of character register 1 when it is 1.
- R9: `wram_en` is 1 only when the CPU address is in $6000-$7FFF, program-bank bit 4 is 0, and the selected character-register bit 4 is 0.
- R10: In 8 KB character mode, the work-RAM disable is taken from character register 0 only. In 4 KB mode, it is taken from the register that picture address bit 12 selects.
- R11: Control bits 1:0 drive `ciram_a10` as follows: 0 gives 0, 1 gives 1, 2 gives picture address bit 10, and 3 gives picture address bit 11.
- R12: `rom_oe` is 1 only for a CPU address in $8000-$FFFF while `cpu_wr` is 0. Writes below $8000 leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| ppu_addr | input | 14 | Picture-processor address |
| prg_bank | output | PBW | Program ROM address lines 14 and up |
| rom_oe | output | 1 | Program ROM output enable |
| wram_en | output | 1 | Work-RAM enable |
| chr_a12 | output | 1 | Character RAM address line 12 |
| ciram_a10 | output | 1 | Nametable address line 10 |

## Verification
The hardest case to reach is the RAM gate toggling with picture address bit 12 in 4 KB mode. Reaching it needs three separate serial loads: control to 4 KB mode, and the two character registers with different bit-4 values. The CPU address is then held in the work-RAM window while only the picture address moves. A further hard case is a loader reset in the middle of a sequence. The bench makes two partial writes, then a bit-7 write, then a full load, and checks that the first two bits are lost.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CHR0 = 2'd1,
        SEL_CHR1 = 2'd2,
        SEL_PRG  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    localparam int REG_W = 5;
    localparam logic [REG_W-1:0] CTRL_RESET = 5'b01100;

    typedef struct packed {
        logic [REG_W-1:0] sr;
        logic [2:0]       cnt;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] chr0;
        logic [REG_W-1:0] chr1;
        logic [REG_W-1:0] prg;
    } ldr_state_t;

endpackage

// File: rtl/mapper_loader.sv
module mapper_loader
    import mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] chr0_o,
    output logic [REG_W-1:0] chr1_o,
    output logic [REG_W-1:0] prg_o
);
    localparam logic [2:0] LAST_CNT = 3'(REG_W - 1);

    ldr_state_t       st_d, st_q;
    logic [REG_W-1:0] full_d;

    always_comb begin
        st_d   = st_q;
        full_d = {wr_data[0], st_q.sr[REG_W-1:1]};
        if (wr_en) begin
            if (wr_data[7]) begin
                st_d.sr        = '0;
                st_d.cnt       = '0;
                st_d.ctrl[3:2] = 2'b11;
            end else if (st_q.cnt == LAST_CNT) begin
                unique case (reg_sel_e'(wr_sel))
                    SEL_CTRL: st_d.ctrl = full_d;
                    SEL_CHR0: st_d.chr0 = full_d;
                    SEL_CHR1: st_d.chr1 = full_d;
                    SEL_PRG:  st_d.prg  = full_d;
                    default:  st_d.prg  = full_d;
                endcase
                st_d.sr  = '0;
                st_d.cnt = '0;
            end else begin
                st_d.sr  = full_d;
                st_d.cnt = st_q.cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign chr0_o = st_q.chr0;
    assign chr1_o = st_q.chr1;
    assign prg_o  = st_q.prg;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT);

    // R2
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && st_q.cnt == LAST_CNT) |=> (st_q.cnt == 3'd0));

    // R3
    reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> (st_q.ctrl[3:2] == 2'b11 && st_q.cnt == 3'd0));

endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map #(
    parameter int PBW = 4
) (
    input  logic [1:0]     prg_mode,
    input  logic [PBW-1:0] prg_sel,
    input  logic           cpu_a14,
    output logic [PBW-1:0] bank_o
);
    localparam logic [PBW-1:0] LAST_BANK = '1;

    logic [PBW-1:0] wide_bank;

    generate
        if (PBW == 1) begin : g_one
            assign wide_bank = cpu_a14;
        end else begin : g_many
            assign wide_bank = {prg_sel[PBW-1:1], cpu_a14};
        end
    endgenerate

    always_comb begin
        unique case (prg_mode)
            2'd2:    bank_o = cpu_a14 ? prg_sel : '0;
            2'd3:    bank_o = cpu_a14 ? LAST_BANK : prg_sel;
            default: bank_o = wide_bank;
        endcase
    end

endmodule

// File: rtl/mapper_ppu_map.sv
module mapper_ppu_map
    import mapper_pkg::*;
(
    input  logic             chr_mode4k,
    input  logic [1:0]       mirror,
    input  logic [REG_W-1:0] chr0,
    input  logic [REG_W-1:0] chr1,
    input  logic [13:0]      ppu_addr,
    output logic             chr_a12_o,
    output logic             ram_dis_o,
    output logic             ciram_a10_o
);
    logic [REG_W-1:0] sel_reg;

    always_comb begin
        sel_reg = (chr_mode4k && ppu_addr[12]) ? chr1 : chr0;
        chr_a12_o = chr_mode4k ? sel_reg[0] : ppu_addr[12];
        ram_dis_o = sel_reg[REG_W-1];
        unique case (mirror_e'(mirror))
            MIR_ONE_LO: ciram_a10_o = 1'b0;
            MIR_ONE_HI: ciram_a10_o = 1'b1;
            MIR_VERT:   ciram_a10_o = ppu_addr[10];
            MIR_HORZ:   ciram_a10_o = ppu_addr[11];
            default:    ciram_a10_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_KB = 256,
    parameter int PBW    = $clog2(PRG_KB / 16)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [15:0]    cpu_addr,
    input  logic [7:0]     cpu_data,
    input  logic           cpu_wr,
    input  logic [13:0]    ppu_addr,
    output logic [PBW-1:0] prg_bank,
    output logic           rom_oe,
    output logic           wram_en,
    output logic           chr_a12,
    output logic           ciram_a10
);
    logic [REG_W-1:0] ctrl_q, chr0_q, chr1_q, prg_q;
    logic             ram_dis;
    logic             in_wram;

    mapper_loader u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cpu_wr && cpu_addr[15]),
        .wr_sel  (cpu_addr[14:13]),
        .wr_data (cpu_data),
        .ctrl_o  (ctrl_q),
        .chr0_o  (chr0_q),
        .chr1_o  (chr1_q),
        .prg_o   (prg_q)
    );

    mapper_prg_map #(.PBW(PBW)) u_prg (
        .prg_mode (ctrl_q[3:2]),
        .prg_sel  (prg_q[PBW-1:0]),
        .cpu_a14  (cpu_addr[14]),
        .bank_o   (prg_bank)
    );

    mapper_ppu_map u_ppu (
        .chr_mode4k  (ctrl_q[4]),
        .mirror      (ctrl_q[1:0]),
        .chr0        (chr0_q),
        .chr1        (chr1_q),
        .ppu_addr    (ppu_addr),
        .chr_a12_o   (chr_a12),
        .ram_dis_o   (ram_dis),
        .ciram_a10_o (ciram_a10)
    );

    assign in_wram = (cpu_addr[15:13] == 3'b011);
    assign wram_en = in_wram && !prg_q[REG_W-1] && !ram_dis;
    assign rom_oe  = cpu_addr[15] && !cpu_wr;

    // R9
    wram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wram_en |-> (!prg_q[REG_W-1] && cpu_addr[15:13] == 3'b011));

    // R4
    fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3:2] == 2'b11 && cpu_addr[14]) |-> (prg_bank == '1));

    // R12
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |=>
            ($stable(ctrl_q) && $stable(chr0_q) && $stable(chr1_q) && $stable(prg_q)));

endmodule

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;
    localparam int PBW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = 16'h0000;
    logic [7:0]     cpu_data = 8'h00;
    logic           cpu_wr = 1'b0;
    logic [13:0]    ppu_addr = 14'h0000;
    logic [PBW-1:0] prg_bank;
    logic           rom_oe, wram_en, chr_a12, ciram_a10;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cart_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
        .rom_oe(rom_oe), .wram_en(wram_en), .chr_a12(chr_a12), .ciram_a10(ciram_a10)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic load_reg(input logic [1:0] sel, input logic [4:0] v);
        for (int i = 0; i < 5; i++) cpu_write({1'b1, sel, 13'h0}, {7'b0, v[i]});
    endtask

    task automatic look(input logic [15:0] a, input logic [13:0] p);
        cpu_addr = a; ppu_addr = p; #1;
    endtask

    task automatic t_reset;
        look(16'h8000, 14'h0C00);
        check("R1 8000 bank", prg_bank, 0);
        check("R1 ciram", ciram_a10, 0);
        look(16'hC000, 14'h1000);
        check("R1 C000 bank", prg_bank, 15);
        check("R1 chr_a12", chr_a12, 1);
        look(16'h6000, 14'h0000);
        check("R1 wram", wram_en, 1);
    endtask

    task automatic t_mode3;
        load_reg(2'd3, 5'd5);
        look(16'h8000, 0); check("R2 R4 8000", prg_bank, 5);
        look(16'hC123, 0); check("R4 C000", prg_bank, 15);
    endtask

    task automatic t_mode2;
        load_reg(2'd0, 5'b01000);
        look(16'h8000, 0); check("R5 8000", prg_bank, 0);
        look(16'hC000, 0); check("R5 C000", prg_bank, 5);
    endtask

    task automatic t_32k;
        load_reg(2'd0, 5'b00000);
        look(16'h8000, 0); check("R6 8000", prg_bank, 4);
        look(16'hC000, 0); check("R6 C000", prg_bank, 5);
        load_reg(2'd0, 5'b00100);
        look(16'h8000, 0); check("R6 mode1 8000", prg_bank, 4);
    endtask

    task automatic t_bit7;
        load_reg(2'd0, 5'b00011);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'hE000, 8'h01);
        cpu_write(16'h8000, 8'h80);
        look(16'hC000, 14'h0800); check("R3 mode forced", prg_bank, 15);
        check("R3 mirror kept", ciram_a10, 1);
        load_reg(2'd3, 5'd3);
        look(16'h8000, 0); check("R3 loader emptied", prg_bank, 3);
    endtask

    task automatic t_chr;
        load_reg(2'd0, 5'b01100);
        load_reg(2'd1, 5'd1);
        look(16'h0000, 14'h0000); check("R7 8k low", chr_a12, 0);
        look(16'h0000, 14'h1000); check("R7 8k high", chr_a12, 1);
        load_reg(2'd0, 5'b11100);
        load_reg(2'd2, 5'd0);
        look(16'h0000, 14'h0000); check("R8 4k reg0", chr_a12, 1);
        look(16'h0000, 14'h1000); check("R8 4k reg1", chr_a12, 0);
    endtask

    task automatic t_wram;
        load_reg(2'd0, 5'b01100);
        load_reg(2'd1, 5'h00);
        load_reg(2'd2, 5'h00);
        load_reg(2'd3, 5'h10);
        look(16'h7FFF, 0); check("R9 prg disable", wram_en, 0);
        load_reg(2'd3, 5'h00);
        look(16'h5FFF, 0); check("R9 below window", wram_en, 0);
        look(16'h8000, 0); check("R9 above window", wram_en, 0);
        load_reg(2'd1, 5'h10);
        look(16'h6000, 0); check("R9 chr0 disable", wram_en, 0);
        load_reg(2'd1, 5'h00);
        load_reg(2'd2, 5'h10);
        look(16'h6000, 14'h1000); check("R10 8k chr1 ignored", wram_en, 1);
        load_reg(2'd0, 5'b11100);
        look(16'h6000, 14'h0000); check("R10 4k a12 low", wram_en, 1);
        look(16'h6000, 14'h1000); check("R10 4k a12 high", wram_en, 0);
        look(16'h6000, 14'h0000); check("R10 4k toggles back", wram_en, 1);
    endtask

    task automatic t_mirror;
        load_reg(2'd0, 5'b01100);
        look(0, 14'h0C00); check("R11 one lo", ciram_a10, 0);
        load_reg(2'd0, 5'b01101);
        look(0, 14'h0000); check("R11 one hi", ciram_a10, 1);
        load_reg(2'd0, 5'b01110);
        look(0, 14'h0400); check("R11 vert a10", ciram_a10, 1);
        look(0, 14'h0800); check("R11 vert a11", ciram_a10, 0);
        load_reg(2'd0, 5'b01111);
        look(0, 14'h0800); check("R11 horz a11", ciram_a10, 1);
        look(0, 14'h0400); check("R11 horz a10", ciram_a10, 0);
    endtask

    task automatic t_rom;
        load_reg(2'd3, 5'd2);
        look(16'h9000, 0); check("R12 rom read", rom_oe, 1);
        look(16'h7000, 0); check("R12 rom low", rom_oe, 0);
        for (int i = 0; i < 5; i++) cpu_write(16'h6000, 8'h01);
        for (int i = 0; i < 5; i++) cpu_write(16'h4000, 8'h80);
        look(16'h8000, 0); check("R12 low writes ignored", prg_bank, 2);
        look(16'hC000, 0); check("R12 mode unchanged", prg_bank, 15);
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_data = 8'h00; cpu_wr = 1'b1; #1;
        check("R12 rom off on write", rom_oe, 0);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h8000, 8'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode3();
        t_mode2();
        t_32k();
        t_bit7();
        t_chr();
        t_wram();
        t_mirror();
        t_rom();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule